// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Sticky Framing Check

This block receives asynchronous serial frames on one line. It oversamples the line with a 16x tick enable and decides each bit by a three-sample vote near the middle of the bit. It supports an 8-bit frame with a selectable bit clock, a 9-bit frame on a fixed clock, and a 9-bit frame with a selectable bit clock. The received byte, the ninth bit and a receive-complete flag are held in a small control/status register that software reads and writes through a simple port.

An optional framing check samples the stop bit of every frame. A stop bit of 0 sets an error flag. That flag stays set until software clears it or the block is reset. When the check is on, the receive-complete flag is raised at the stop bit. When the check is off, it is raised one bit earlier, at the last data bit. Bit 7 of the control register is shared. With the check enabled it reads and writes the error flag. With the check disabled it reads and writes the upper mode bit.

Control register layout:

| Bit | Content |
|-----|---------|
| 7 | Error flag when `fe_en_i` = 1, otherwise the upper mode bit |
| 6 | Lower mode bit |
| 5 | Receive enable |
| 3 | Ninth bit |
| 0 | Receive-complete flag |

All other bits read 0. The mode is {bit7, bit6}:

| Mode | Frame |
|------|-------|
| 00 | Synchronous shift mode; the receiver stays idle |
| 01 | 8-bit frame |
| 10 | 9-bit frame on a fixed clock |
| 11 | 9-bit frame on a selectable clock |

Top module: `serial_rx_port`

## Requirements
- R1: A frame starts only when all three hold: receive enable (bit 5) is 1, the mode is not 00, and the synchronized line falls from 1 to 0. With enable 0, or in mode 00, a full frame on the line leaves the flag and the data unchanged.
- R2: The start bit is confirmed by a majority of the 7th, 8th and 9th ticks after the falling edge. If the vote gives 1, the receiver returns to idle, raises no flag and stores no data.
- R3: Data bits arrive LSB first. Mode 01 takes 8 data bits. Modes 10 and 11 take 9 data bits, and the ninth is stored in bit 3 of the control register.
- R4: In mode 01, bit 3 is loaded with the stop-bit value when the framing check is on. When the check is off, bit 3 is left unchanged.
- R5: With `fe_en_i` = 1, a stop bit sampled as 0 sets `frame_err_o`. With `fe_en_i` = 0, a stop bit of 0 does not set it.
- R6: `frame_err_o` is sticky. Later frames with good stop bits do not clear it. Only a register write with `fe_en_i` = 1 and bit 7 = 0, or a reset, clears it.
- R7: Bit 7 reads and writes the error flag when `fe_en_i` = 1, and the upper mode bit when `fe_en_i` = 0. A write through bit 7 never changes the other of the two.
- R8: With the check on, the flag rises at the stop-bit decision, so it is still 0 shortly after the stop bit begins. With the check off, it rises at the last data bit's decision, before the stop bit begins.
- R9: The flag (bit 0) stays 1 until software writes 0 to it. A frame that completes while the flag is 1 is discarded, and the held data and ninth bit are kept.
- R10: Modes 01 and 11 count `tick_b_i` when `tick_sel_i` = 1 and `tick_a_i` otherwise. Mode 10 always counts `tick_a_i`.
- R11: After reset, the register reads 0x00 and the data, flag and error outputs are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tick_a_i | input | 1 | 16x oversampling enable, source A |
| tick_b_i | input | 1 | 16x oversampling enable, source B |
| tick_sel_i | input | 1 | Receive tick source select for modes 01 and 11 |
| rxd_i | input | 1 | Serial receive line |
| fe_en_i | input | 1 | Framing check enable; also steers bit 7 |
| reg_we_i | input | 1 | Control register write strobe |
| reg_wdata_i | input | 8 | Control register write data |
| reg_rdata_o | output | 8 | Control register read data |
| rx_data_o | output | 8 | Last accepted byte |
| rx_bit9_o | output | 1 | Ninth bit / stop bit (register bit 3) |
| rx_flag_o | output | 1 | Receive-complete flag |
| frame_err_o | output | 1 | Sticky framing error flag |

## Verification
The assertions assume three things about the inputs:
- `fe_en_i` and the mode bits do not change while a frame is in flight.
- The line is high before each start bit.
- Software writes do not land in the same cycle as a frame commit.

The bench respects all three. It changes modes and `fe_en_i` only while the line idles high, issues register writes only between frames, and leaves at least two idle bit times after each stop bit. Bit periods are exact multiples of 16 ticks of whichever source the mode selects, so every vote falls well inside a bit.

// File: rtl/serial_rx_pkg.sv
package serial_rx_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_START, ST_DATA, ST_STOP, ST_DONE
  } rx_state_e;

  typedef enum logic [1:0] {
    MODE_SHIFT = 2'b00,
    MODE_8VAR  = 2'b01,
    MODE_9FIX  = 2'b10,
    MODE_9VAR  = 2'b11
  } rx_mode_e;

  localparam int unsigned CtlShared = 7;
  localparam int unsigned CtlModeLo = 6;
  localparam int unsigned CtlEnable = 5;
  localparam int unsigned CtlBit9   = 3;
  localparam int unsigned CtlFlag   = 0;
endpackage

// File: rtl/serial_rx_sync.sv
module serial_rx_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sr_q <= '1;  // idle line is high
    else         sr_q <= {sr_q[STAGES-2:0], d_i};
  end

  assign q_o = sr_q[STAGES-1];
endmodule

// File: rtl/serial_rx_sampler.sv
module serial_rx_sampler #(
  parameter int unsigned OSR = 16,
  parameter int unsigned MID = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic restart_i,
  input  logic tick_i,
  input  logic rxd_i,
  output logic decide_o,
  output logic bit_o
);
  localparam int unsigned CW = $clog2(OSR);

  logic [CW-1:0] cnt_q;
  logic [1:0]    vote_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      vote_q <= '0;
    end else if (restart_i) begin
      cnt_q  <= '0;
      vote_q <= '0;
    end else if (tick_i) begin
      cnt_q <= cnt_q + 1'b1;  // wraps every OSR ticks
      if (cnt_q == CW'(MID - 2)) vote_q[0] <= rxd_i;
      if (cnt_q == CW'(MID - 1)) vote_q[1] <= rxd_i;
    end
  end

  assign decide_o = tick_i && !restart_i && (cnt_q == CW'(MID));
  assign bit_o    = (vote_q[0] & vote_q[1]) | (vote_q[0] & rxd_i) | (vote_q[1] & rxd_i);
endmodule

// File: rtl/serial_rx_port.sv
module serial_rx_port
  import serial_rx_pkg::*;
#(
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned OSR       = 16,
  parameter int unsigned SYNC_STGS = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_a_i,
  input  logic              tick_b_i,
  input  logic              tick_sel_i,
  input  logic              rxd_i,
  input  logic              fe_en_i,
  input  logic              reg_we_i,
  input  logic [7:0]        reg_wdata_i,
  output logic [7:0]        reg_rdata_o,
  output logic [DATA_W-1:0] rx_data_o,
  output logic              rx_bit9_o,
  output logic              rx_flag_o,
  output logic              frame_err_o
);
  localparam int unsigned IW  = $clog2(DATA_W + 2);
  localparam int unsigned MID = OSR / 2;

  rx_state_e   state_q;
  rx_mode_e    mode;
  logic        mode_hi_q, mode_lo_q, rx_en_q, bit9_q, flag_q, fe_q;
  logic [DATA_W-1:0] data_q, data_sh_q;
  logic        b9_sh_q, stop_sh_q, stop_seen_q;
  logic [IW-1:0] idx_q;
  logic        tick, rxd_s, rxd_prev_q, start_go, decide, vbit, nine, commit;
  logic [IW-1:0] last_idx;
  logic        unused_wdata;

  assign mode     = rx_mode_e'({mode_hi_q, mode_lo_q});
  assign nine     = mode_hi_q;
  assign last_idx = nine ? IW'(DATA_W) : IW'(DATA_W - 1);

  always_comb begin
    unique case (mode)
      MODE_9FIX: tick = tick_a_i;
      default:   tick = tick_sel_i ? tick_b_i : tick_a_i;
    endcase
  end

  serial_rx_sync #(.STAGES(SYNC_STGS)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (rxd_i),
    .q_o   (rxd_s)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rxd_prev_q <= 1'b1;
    else         rxd_prev_q <= rxd_s;
  end

  assign start_go = (state_q == ST_IDLE) && rx_en_q && (mode != MODE_SHIFT)
                    && rxd_prev_q && !rxd_s;

  serial_rx_sampler #(.OSR(OSR), .MID(MID)) u_samp (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .restart_i(start_go),
    .tick_i   (tick),
    .rxd_i    (rxd_s),
    .decide_o (decide),
    .bit_o    (vbit)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      idx_q       <= '0;
      data_sh_q   <= '0;
      b9_sh_q     <= 1'b0;
      stop_sh_q   <= 1'b1;
      stop_seen_q <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (start_go) state_q <= ST_START;
        ST_START: if (decide) begin
          if (vbit) state_q <= ST_IDLE;  // false start
          else begin
            state_q     <= ST_DATA;
            idx_q       <= '0;
            stop_seen_q <= 1'b0;
          end
        end
        ST_DATA: if (decide) begin
          if (idx_q < IW'(DATA_W)) data_sh_q <= {vbit, data_sh_q[DATA_W-1:1]};
          else                     b9_sh_q   <= vbit;
          idx_q <= idx_q + 1'b1;
          if (idx_q == last_idx) state_q <= fe_en_i ? ST_STOP : ST_DONE;
        end
        ST_STOP: if (decide) begin
          stop_sh_q   <= vbit;
          stop_seen_q <= 1'b1;
          state_q     <= ST_DONE;
        end
        default: state_q <= ST_IDLE;  // ST_DONE: commit slot
      endcase
    end
  end

  assign commit = (state_q == ST_DONE) && !flag_q;

  // register file; a hardware commit overrides a same-cycle write
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_hi_q <= 1'b0;
      mode_lo_q <= 1'b0;
      rx_en_q   <= 1'b0;
      bit9_q    <= 1'b0;
      flag_q    <= 1'b0;
      fe_q      <= 1'b0;
      data_q    <= '0;
    end else begin
      if (reg_we_i) begin
        if (fe_en_i) fe_q      <= reg_wdata_i[CtlShared];
        else         mode_hi_q <= reg_wdata_i[CtlShared];
        mode_lo_q <= reg_wdata_i[CtlModeLo];
        rx_en_q   <= reg_wdata_i[CtlEnable];
        bit9_q    <= reg_wdata_i[CtlBit9];
        flag_q    <= reg_wdata_i[CtlFlag];
      end
      if (commit) begin
        data_q <= data_sh_q;
        flag_q <= 1'b1;
        if (nine)             bit9_q <= b9_sh_q;
        else if (stop_seen_q) bit9_q <= stop_sh_q;
        if (stop_seen_q && !stop_sh_q) fe_q <= 1'b1;
      end
    end
  end

  assign unused_wdata = ^{reg_wdata_i[4], reg_wdata_i[2:1]};

  always_comb begin
    reg_rdata_o            = '0;
    reg_rdata_o[CtlShared] = fe_en_i ? fe_q : mode_hi_q;
    reg_rdata_o[CtlModeLo] = mode_lo_q;
    reg_rdata_o[CtlEnable] = rx_en_q;
    reg_rdata_o[CtlBit9]   = bit9_q;
    reg_rdata_o[CtlFlag]   = flag_q;
  end

  assign rx_data_o   = data_q;
  assign rx_bit9_o   = bit9_q;
  assign rx_flag_o   = flag_q;
  assign frame_err_o = fe_q;
endmodule

// File: rtl/serial_rx_port_chk.sv
module serial_rx_port_chk
  import serial_rx_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              we,
  input logic              fe_en,
  input logic              rx_en,
  input rx_state_e         state,
  input logic              flag,
  input logic              fe,
  input logic [DATA_W-1:0] data
);
  AST_IDLE_WITHOUT_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE) && !rx_en |=> (state == ST_IDLE)); // R1

  AST_FE_ONLY_ON_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
    !fe && !we && (state != ST_DONE) |=> !fe); // R5

  AST_FE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    fe && !(we && fe_en) |=> fe); // R6

  AST_FLAG_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    flag && !we |=> flag); // R9

  AST_DATA_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    flag |=> $stable(data)); // R9
endmodule

bind serial_rx_port serial_rx_port_chk #(.DATA_W(DATA_W)) u_chk (
  .clk  (clk_i),
  .rst_n(rst_ni),
  .we   (reg_we_i),
  .fe_en(fe_en_i),
  .rx_en(rx_en_q),
  .state(state_q),
  .flag (rx_flag_o),
  .fe   (frame_err_o),
  .data (rx_data_o)
);

// File: tb/tb_serial_rx_port.sv
`timescale 1ns/1ps
module tb_serial_rx_port;
  localparam int CPB_A = 64;  // 16 ticks x 4 clocks
  localparam int CPB_B = 48;  // 16 ticks x 3 clocks

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick_a = 1'b0, tick_b = 1'b0, tick_sel = 1'b0;
  logic       rxd = 1'b1, fe_en = 1'b0, we = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata, data;
  logic       bit9, flag, ferr;
  int         n_chk = 0, n_fail = 0;
  int         ca = 0, cb = 0;
  bit         done = 1'b0;

  always #10 clk = ~clk;

  always @(posedge clk) begin
    ca     <= (ca == 3) ? 0 : ca + 1;
    cb     <= (cb == 2) ? 0 : cb + 1;
    tick_a <= (ca == 3);
    tick_b <= (cb == 2);
  end

  serial_rx_port dut (
    .clk_i(clk), .rst_ni(rst_n), .tick_a_i(tick_a), .tick_b_i(tick_b),
    .tick_sel_i(tick_sel), .rxd_i(rxd), .fe_en_i(fe_en), .reg_we_i(we),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .rx_data_o(data),
    .rx_bit9_o(bit9), .rx_flag_o(flag), .frame_err_o(ferr)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic clocks(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [7:0] cw(input logic b7, mlo, en, b9, fl);
    return {b7, mlo, en, 1'b0, b9, 2'b00, fl};
  endfunction

  task automatic wr(input logic [7:0] v);
    @(negedge clk); we = 1'b1; wdata = v;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic send_head(input logic [8:0] d, input int nb, input int cpb);
    rxd = 1'b0; clocks(cpb);
    for (int i = 0; i < nb; i++) begin
      rxd = d[i]; clocks(cpb);
    end
  endtask

  task automatic send_stop(input logic v, input int cpb);
    rxd = v; clocks(cpb);
    rxd = 1'b1; clocks(2 * cpb);
  endtask

  task automatic t_reset;
    chk("R11 rdata", rdata, 8'h00);
    chk("R11 data", data, 0);
    chk("R11 flag", flag, 0);
    chk("R11 ferr", ferr, 0);
  endtask

  task automatic t_disabled;
    wr(cw(0, 1, 0, 0, 0));
    send_head(9'h0A5, 8, CPB_A); send_stop(1, CPB_A);
    chk("R1 enable off flag", flag, 0);
    chk("R1 enable off data", data, 0);
    wr(cw(0, 0, 1, 0, 0));
    send_head(9'h0A5, 8, CPB_A); send_stop(1, CPB_A);
    chk("R1 mode 00 flag", flag, 0);
  endtask

  task automatic t_false_start;
    wr(cw(0, 1, 1, 0, 0));
    rxd = 1'b0; clocks(12); rxd = 1'b1; clocks(3 * CPB_A);
    chk("R2 false start flag", flag, 0);
    chk("R2 false start data", data, 0);
    send_head(9'h0A5, 8, CPB_A); send_stop(1, CPB_A);
    chk("R2 good start flag", flag, 1);
    chk("R3 mode 01 data", data, 8'hA5);
  endtask

  task automatic t_mode1_check_off;
    fe_en = 1'b0;
    wr(cw(0, 1, 1, 0, 0));
    send_head(9'h03C, 8, CPB_A);
    clocks(4);
    chk("R8 check off early flag", flag, 1);
    send_stop(1, CPB_A);
    chk("R3 data 3C", data, 8'h3C);
    chk("R4 check off bit3 kept", rdata[3], 0);
  endtask

  task automatic t_mode1_check_on;
    fe_en = 1'b1;
    wr(cw(0, 1, 1, 0, 0));
    send_head(9'h0C3, 8, CPB_A);
    clocks(4);
    chk("R8 check on no early flag", flag, 0);
    send_stop(1, CPB_A);
    chk("R8 check on flag at stop", flag, 1);
    chk("R4 check on bit3 = stop", rdata[3], 1);
    chk("R5 good stop ferr", ferr, 0);
  endtask

  task automatic t_framing;
    fe_en = 1'b1;
    wr(cw(0, 1, 1, 0, 0));
    send_head(9'h05A, 8, CPB_A); send_stop(0, CPB_A);
    chk("R5 bad stop sets ferr", ferr, 1);
    chk("R7 bit7 shows ferr", rdata[7], 1);
    fe_en = 1'b0; clocks(1);
    chk("R7 bit7 shows mode", rdata[7], 0);
    chk("R7 mode lo intact", rdata[6], 1);
    fe_en = 1'b1;
    wr(cw(1, 1, 1, 0, 0));
    send_head(9'h011, 8, CPB_A); send_stop(1, CPB_A);
    chk("R6 good frame keeps ferr", ferr, 1);
    chk("R6 good frame data", data, 8'h11);
    wr(cw(0, 1, 1, 0, 0));
    chk("R6 write 0 clears ferr", ferr, 0);
    chk("R7 rdata after clear", rdata, 8'h60);
    fe_en = 1'b0; clocks(1);
    chk("R7 mode hi untouched", rdata[7], 0);
  endtask

  task automatic t_check_off_bad_stop;
    fe_en = 1'b0;
    wr(cw(0, 1, 1, 0, 0));
    send_head(9'h077, 8, CPB_A); send_stop(0, CPB_A);
    chk("R5 check off no ferr", ferr, 0);
    chk("R5 check off flag", flag, 1);
  endtask

  task automatic t_discard;
    send_head(9'h099, 8, CPB_A); send_stop(1, CPB_A);
    chk("R9 data held", data, 8'h77);
    chk("R9 flag held", flag, 1);
  endtask

  task automatic t_mode3;
    fe_en = 1'b0;
    tick_sel = 1'b1;
    wr(cw(1, 1, 1, 0, 0));
    fe_en = 1'b1;
    send_head(9'h15A, 9, CPB_B);
    clocks(4);
    chk("R8 mode 11 no early flag", flag, 0);
    send_stop(1, CPB_B);
    chk("R10 mode 11 tick b data", data, 8'h5A);
    chk("R3 ninth bit", bit9, 1);
    chk("R5 mode 11 ferr", ferr, 0);
  endtask

  task automatic t_mode2;
    fe_en = 1'b0;
    tick_sel = 1'b1;
    wr(cw(1, 0, 1, 1, 0));
    send_head(9'h0C3, 9, CPB_A); send_stop(1, CPB_A);
    chk("R10 mode 10 tick a data", data, 8'hC3);
    chk("R3 ninth bit zero", bit9, 0);
    chk("R10 flag", flag, 1);
  endtask

  initial begin
    clocks(3); rst_n = 1'b1; clocks(3);
    t_reset();
    t_disabled();
    t_false_start();
    t_mode1_check_off();
    t_mode1_check_on();
    t_framing();
    t_check_off_bad_stop();
    t_discard();
    t_mode3();
    t_mode2();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end
endmodule